// File: doc/BRIEF.md
# Synchronous Dual-Port Burst RAM

A true dual-port synchronous static memory shared by two symmetrical ports, a left one and a right one. Each port has its own clock. On that clock it captures its address, write data and control inputs into registers. Both ports reach the same storage and may address the same word in the same cycle.

Each port holds its address in a burst counter. An active-low clear input sets the counter to zero. An active-low load strobe takes the external address, and an active-low step input adds one to it, so a burst can run through consecutive words without a new address on every cycle.

A port is selected only when its active-low select is low and its active-high select is high. A write uses two byte lanes of 9 bits, each with its own enable. Read data leaves through one output register (flow-through) or through two (pipelined), and a static input on each port chooses which. An active-low output enable gates the drive flag of the port without waiting for a clock.

The full-size device uses `ADDR_W` = 13 (8K words), and `ADDR_W` = 12 gives the 4K variant. The default of 11 keeps elaboration small. The same-cycle collision rules apply when both port clocks share an edge.

Top module: `dp_burst_ram`

## Requirements
- R1: After reset, `drive_l` and `drive_r` are low and both burst counters hold address 0, so a write issued with no load, step or clear lands at word 0.
- R2: A port is selected only when `sel_lo_*_n` = 0 and `sel_hi_*` = 1. In any other combination the port writes nothing and its read raises no drive flag.
- R3: On a write (`rd_wr_*` = 0), bits 8:0 change only if `lo_be_*_n` = 0 and bits 17:9 change only if `hi_be_*_n` = 0. A write with both enables high changes nothing.
- R4: With `two_stage_*` = 0, a read whose inputs are captured at rising edge k shows its data, with the drive flag high, after edge k+1. The flag is low between edge k and edge k+1.
- R5: With `two_stage_*` = 1, the same read shows its data after edge k+2, and the drive flag is low after edge k+1.
- R6: The counter control inputs are all active low. Their priority is clear (to 0), then load (the external address), then step (+1). With none of them asserted, the counter holds its value.
- R7: A step from the highest address wraps the counter to 0.
- R8: `drive_*` equals the port's read-valid state gated by `out_en_*_n` = 0. A change of `out_en_*_n` takes effect with no clock edge.
- R9: A word written by either port is read back by both ports.
- R10: When both ports write the same word in the same cycle, the left port's data wins on every lane the left port enables. The right port's data still lands on lanes that only the right port enables.
- R11: When one port reads a word that the other port writes in the same cycle, the read returns the data held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_l | input | 1 | Left port clock |
| clk_r | input | 1 | Right port clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on each port clock |
| addr_l | input | ADDR_W | Left external address |
| ld_l_n | input | 1 | Left counter load strobe, active low |
| step_l_n | input | 1 | Left counter increment, active low |
| clr_l_n | input | 1 | Left counter clear, active low |
| sel_lo_l_n | input | 1 | Left select, active low |
| sel_hi_l | input | 1 | Left select, active high |
| rd_wr_l | input | 1 | Left direction: 1 read, 0 write |
| hi_be_l_n | input | 1 | Left upper lane (bits 17:9) enable, active low |
| lo_be_l_n | input | 1 | Left lower lane (bits 8:0) enable, active low |
| out_en_l_n | input | 1 | Left output enable, active low |
| two_stage_l | input | 1 | Left read latency: 0 flow-through, 1 pipelined |
| din_l | input | DATA_W | Left write data |
| dout_l | output | DATA_W | Left read data |
| drive_l | output | 1 | Left output drive flag |
| addr_r | input | ADDR_W | Right external address |
| ld_r_n | input | 1 | Right counter load strobe, active low |
| step_r_n | input | 1 | Right counter increment, active low |
| clr_r_n | input | 1 | Right counter clear, active low |
| sel_lo_r_n | input | 1 | Right select, active low |
| sel_hi_r | input | 1 | Right select, active high |
| rd_wr_r | input | 1 | Right direction: 1 read, 0 write |
| hi_be_r_n | input | 1 | Right upper lane enable, active low |
| lo_be_r_n | input | 1 | Right lower lane enable, active low |
| out_en_r_n | input | 1 | Right output enable, active low |
| two_stage_r | input | 1 | Right read latency: 0 flow-through, 1 pipelined |
| din_r | input | DATA_W | Right write data |
| dout_r | output | DATA_W | Right read data |
| drive_r | output | 1 | Right output drive flag |

## Verification
The hardest situations to reach are the same-cycle collisions, because they need both ports' registered requests to meet on one shared clock edge. The bench gets there by driving both port clocks from one clock. It presents the left and right requests on the same falling edge, so both are captured together. The collision cases are:
- two full-word writes to one word;
- a left write to one lane against a right write to both lanes;
- a left write against a right read of the same word.

Lane merging and counter priority are reached with a preload followed by readback through a plain load. This means a wrong burst address shows up as wrong data.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  localparam int unsigned NUM_PORTS = 2;

  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_INC  = 2'd1,
    CNT_LOAD = 2'd2,
    CNT_CLR  = 2'd3
  } cnt_op_e;

  // Burst counter control decode: clear beats load beats step.
  function automatic cnt_op_e cnt_decode(input logic clr_n,
                                         input logic ld_n,
                                         input logic step_n);
    if (!clr_n)       return CNT_CLR;
    else if (!ld_n)   return CNT_LOAD;
    else if (!step_n) return CNT_INC;
    else              return CNT_HOLD;
  endfunction

endpackage

// File: rtl/dpr_port_front.sv
module dpr_port_front
  import dpr_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              rst_sync_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ld_n,
  input  logic              step_n,
  input  logic              clr_n,
  input  logic              sel_lo_n,
  input  logic              sel_hi,
  input  logic              rd_wr,
  input  logic              hi_be_n,
  input  logic              lo_be_n,
  input  logic [DATA_W-1:0] din,
  output logic [ADDR_W-1:0] addr_q,
  output logic              we_q,
  output logic              re_q,
  output logic [1:0]        lanes_q,
  output logic [DATA_W-1:0] wdata_q
);

  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_TOP = '1;

  // Reset: asserted asynchronously, released on this port's clock.
  logic [1:0] sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_sync_n = sync_q[1];

  // Next state.
  cnt_op_e           op;
  logic [ADDR_W-1:0] addr_d;
  logic              sel;
  logic [1:0]        lanes_d;
  logic              we_d;
  logic              re_d;
  logic              wdata_en;

  always_comb begin
    op = cnt_decode(clr_n, ld_n, step_n);
    unique case (op)
      CNT_CLR:  addr_d = '0;
      CNT_LOAD: addr_d = addr_i;
      CNT_INC:  addr_d = addr_q + ADDR_ONE;
      default:  addr_d = addr_q;
    endcase
    sel      = !sel_lo_n && sel_hi;
    lanes_d  = {!hi_be_n, !lo_be_n};
    we_d     = sel && !rd_wr && (|lanes_d);
    re_d     = sel && rd_wr;
    wdata_en = sel && !rd_wr;
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_q  <= '0;
      we_q    <= 1'b0;
      re_q    <= 1'b0;
      lanes_q <= 2'b00;
    end else begin
      addr_q  <= addr_d;
      we_q    <= we_d;
      re_q    <= re_d;
      lanes_q <= lanes_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wdata_en) wdata_q <= din;
  end

  // Checks next to the counter and the select decode.
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !clr_n |=> (addr_q == '0));
  p_load_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clr_n && !ld_n) |=> (addr_q == $past(addr_i)));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clr_n && ld_n && step_n) |=> $stable(addr_q));
  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clr_n && ld_n && !step_n && addr_q == ADDR_TOP) |=> (addr_q == '0));
  p_deselect_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sel_lo_n || !sel_hi) |=> (!we_q && !re_q));

endmodule

// File: rtl/dpr_xor_bank.sv
module dpr_xor_bank #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 18,
  parameter int unsigned LANE_W = 9
) (
  input  logic                     clk,
  input  logic [DATA_W/LANE_W-1:0] we_lanes,
  input  logic [ADDR_W-1:0]        waddr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [ADDR_W-1:0]        raddr0,
  input  logic [ADDR_W-1:0]        raddr1,
  output logic [DATA_W-1:0]        rdata0,
  output logic [DATA_W-1:0]        rdata1
);

  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned LANES = DATA_W / LANE_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // One writer per bank, lane by lane.
  always_ff @(posedge clk) begin
    for (int ln = 0; ln < LANES; ln++) begin
      if (we_lanes[ln]) mem[waddr][ln*LANE_W +: LANE_W] <= wdata[ln*LANE_W +: LANE_W];
    end
  end

  // Two asynchronous read taps, one at each port's address.
  assign rdata0 = mem[raddr0];
  assign rdata1 = mem[raddr1];

endmodule

// File: rtl/dpr_read_stage.sv
module dpr_read_stage #(
  parameter int unsigned DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              two_stage,
  input  logic              out_en_n,
  input  logic              re_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] dout,
  output logic              drive
);

  logic [DATA_W-1:0] d1_q, d2_q;
  logic              v1_q, v2_q;
  logic              vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= re_i;
      v2_q <= v1_q;
    end
  end

  always_ff @(posedge clk) begin
    if (re_i) d1_q <= word_i;
    if (v1_q) d2_q <= d1_q;
  end

  always_comb begin
    dout  = two_stage ? d2_q : d1_q;
    vld   = two_stage ? v2_q : v1_q;
    drive = vld && !out_en_n;
  end

  p_flow_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!two_stage && re_i) |=> (two_stage || vld));
  p_pipe_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (two_stage && re_i) ##1 two_stage |=> vld);

endmodule

// File: rtl/dp_burst_ram.sv
module dp_burst_ram
  import dpr_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 18,
  parameter int unsigned LANE_W = 9
) (
  input  logic              clk_l,
  input  logic              clk_r,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic              ld_l_n,
  input  logic              step_l_n,
  input  logic              clr_l_n,
  input  logic              sel_lo_l_n,
  input  logic              sel_hi_l,
  input  logic              rd_wr_l,
  input  logic              hi_be_l_n,
  input  logic              lo_be_l_n,
  input  logic              out_en_l_n,
  input  logic              two_stage_l,
  input  logic [DATA_W-1:0] din_l,
  output logic [DATA_W-1:0] dout_l,
  output logic              drive_l,
  input  logic [ADDR_W-1:0] addr_r,
  input  logic              ld_r_n,
  input  logic              step_r_n,
  input  logic              clr_r_n,
  input  logic              sel_lo_r_n,
  input  logic              sel_hi_r,
  input  logic              rd_wr_r,
  input  logic              hi_be_r_n,
  input  logic              lo_be_r_n,
  input  logic              out_en_r_n,
  input  logic              two_stage_r,
  input  logic [DATA_W-1:0] din_r,
  output logic [DATA_W-1:0] dout_r,
  output logic              drive_r
);

  localparam int unsigned NP    = NUM_PORTS;
  localparam int unsigned LANES = DATA_W / LANE_W;

  // Per-port views of the port list.
  logic              clk_p    [NP];
  logic [ADDR_W-1:0] addr_p   [NP];
  logic              ld_p     [NP];
  logic              step_p   [NP];
  logic              clr_p    [NP];
  logic              sel_lo_p [NP];
  logic              sel_hi_p [NP];
  logic              rd_wr_p  [NP];
  logic              hi_be_p  [NP];
  logic              lo_be_p  [NP];
  logic              oe_p     [NP];
  logic              stage_p  [NP];
  logic [DATA_W-1:0] din_p    [NP];
  logic [DATA_W-1:0] dout_p   [NP];
  logic              drive_p  [NP];

  assign clk_p    = '{clk_l, clk_r};
  assign addr_p   = '{addr_l, addr_r};
  assign ld_p     = '{ld_l_n, ld_r_n};
  assign step_p   = '{step_l_n, step_r_n};
  assign clr_p    = '{clr_l_n, clr_r_n};
  assign sel_lo_p = '{sel_lo_l_n, sel_lo_r_n};
  assign sel_hi_p = '{sel_hi_l, sel_hi_r};
  assign rd_wr_p  = '{rd_wr_l, rd_wr_r};
  assign hi_be_p  = '{hi_be_l_n, hi_be_r_n};
  assign lo_be_p  = '{lo_be_l_n, lo_be_r_n};
  assign oe_p     = '{out_en_l_n, out_en_r_n};
  assign stage_p  = '{two_stage_l, two_stage_r};
  assign din_p    = '{din_l, din_r};
  assign dout_l   = dout_p[0];
  assign dout_r   = dout_p[1];
  assign drive_l  = drive_p[0];
  assign drive_r  = drive_p[1];

  // Registered requests.
  logic              rst_sync_p [NP];
  logic [ADDR_W-1:0] addr_q     [NP];
  logic              we_q       [NP];
  logic              re_q       [NP];
  logic [1:0]        lanes_q    [NP];
  logic [DATA_W-1:0] wdata_q    [NP];

  // Bank b, read tap at port p.
  logic [DATA_W-1:0] bank_rd    [NP][NP];
  logic [DATA_W-1:0] word_p     [NP];
  logic [DATA_W-1:0] bank_wd    [NP];
  logic [LANES-1:0]  bank_we    [NP];
  logic              same_word;

  assign same_word = we_q[0] && we_q[1] && (addr_q[0] == addr_q[1]);

  // Left port has write priority on every lane it enables.
  assign bank_we[0] = we_q[0] ? lanes_q[0] : '0;
  assign bank_we[1] = (we_q[1] ? lanes_q[1] : '0) & ~(same_word ? lanes_q[0] : '0);

  for (genvar p = 0; p < NP; p++) begin : g_port
    dpr_port_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_front (
      .clk        (clk_p[p]),
      .rst_n      (rst_n),
      .rst_sync_n (rst_sync_p[p]),
      .addr_i     (addr_p[p]),
      .ld_n       (ld_p[p]),
      .step_n     (step_p[p]),
      .clr_n      (clr_p[p]),
      .sel_lo_n   (sel_lo_p[p]),
      .sel_hi     (sel_hi_p[p]),
      .rd_wr      (rd_wr_p[p]),
      .hi_be_n    (hi_be_p[p]),
      .lo_be_n    (lo_be_p[p]),
      .din        (din_p[p]),
      .addr_q     (addr_q[p]),
      .we_q       (we_q[p]),
      .re_q       (re_q[p]),
      .lanes_q    (lanes_q[p]),
      .wdata_q    (wdata_q[p])
    );

    // A stored word is the XOR of both banks at that address.
    assign word_p[p]  = bank_rd[0][p] ^ bank_rd[1][p];
    assign bank_wd[p] = wdata_q[p] ^ bank_rd[NP-1-p][p];

    dpr_xor_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_bank (
      .clk      (clk_p[p]),
      .we_lanes (bank_we[p]),
      .waddr    (addr_q[p]),
      .wdata    (bank_wd[p]),
      .raddr0   (addr_q[0]),
      .raddr1   (addr_q[1]),
      .rdata0   (bank_rd[p][0]),
      .rdata1   (bank_rd[p][1])
    );

    dpr_read_stage #(.DATA_W(DATA_W)) u_rd (
      .clk       (clk_p[p]),
      .rst_n     (rst_sync_p[p]),
      .two_stage (stage_p[p]),
      .out_en_n  (oe_p[p]),
      .re_i      (re_q[p]),
      .word_i    (word_p[p]),
      .dout      (dout_p[p]),
      .drive     (drive_p[p])
    );
  end

  p_left_wins_r10: assert property (@(posedge clk_l) disable iff (!rst_sync_p[0])
    same_word |-> ((bank_we[1] & lanes_q[0]) == '0));

endmodule

// File: tb/dp_burst_ram_tb.sv
module dp_burst_ram_tb;

  localparam int AW = 11;
  localparam int DW = 18;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic [AW-1:0] addr   [2];
  logic          ld_n   [2], step_n [2], clr_n [2];
  logic          sel_lo_n [2], sel_hi [2], rd_wr [2];
  logic          hi_n   [2], lo_n [2], oe_n [2], two_st [2];
  logic [DW-1:0] din    [2];
  logic [DW-1:0] dout_l, dout_r;
  logic          drive_l, drive_r;

  dp_burst_ram u_dut (
    .clk_l(clk), .clk_r(clk), .rst_n(rst_n),
    .addr_l(addr[0]), .ld_l_n(ld_n[0]), .step_l_n(step_n[0]), .clr_l_n(clr_n[0]),
    .sel_lo_l_n(sel_lo_n[0]), .sel_hi_l(sel_hi[0]), .rd_wr_l(rd_wr[0]),
    .hi_be_l_n(hi_n[0]), .lo_be_l_n(lo_n[0]), .out_en_l_n(oe_n[0]),
    .two_stage_l(two_st[0]), .din_l(din[0]), .dout_l(dout_l), .drive_l(drive_l),
    .addr_r(addr[1]), .ld_r_n(ld_n[1]), .step_r_n(step_n[1]), .clr_r_n(clr_n[1]),
    .sel_lo_r_n(sel_lo_n[1]), .sel_hi_r(sel_hi[1]), .rd_wr_r(rd_wr[1]),
    .hi_be_r_n(hi_n[1]), .lo_be_r_n(lo_n[1]), .out_en_r_n(oe_n[1]),
    .two_stage_r(two_st[1]), .din_r(din[1]), .dout_r(dout_r), .drive_r(drive_r)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] dout_of(input int p);
    return (p == 0) ? dout_l : dout_r;
  endfunction

  function automatic logic drive_of(input int p);
    return (p == 0) ? drive_l : drive_r;
  endfunction

  task automatic idle(input int p);
    sel_lo_n[p] = 1'b1; sel_hi[p] = 1'b1; rd_wr[p] = 1'b1;
    ld_n[p] = 1'b1; step_n[p] = 1'b1; clr_n[p] = 1'b1;
    hi_n[p] = 1'b1; lo_n[p] = 1'b1;
  endtask

  // Counter ops: ctl = {clr_n, ld_n, step_n}.
  task automatic drive_req(input int p, input bit s_lo_n, input bit s_hi, input bit rd,
                           input bit hn, input bit ln, input logic [2:0] ctl,
                           input logic [AW-1:0] a, input logic [DW-1:0] d);
    sel_lo_n[p] = s_lo_n; sel_hi[p] = s_hi; rd_wr[p] = rd;
    hi_n[p] = hn; lo_n[p] = ln;
    clr_n[p] = ctl[2]; ld_n[p] = ctl[1]; step_n[p] = ctl[0];
    addr[p] = a; din[p] = d;
  endtask

  localparam logic [2:0] C_LOAD = 3'b101;
  localparam logic [2:0] C_STEP = 3'b110;
  localparam logic [2:0] C_HOLD = 3'b111;

  task automatic wr(input int p, input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input bit hn, input bit ln);
    drive_req(p, 1'b0, 1'b1, 1'b0, hn, ln, C_LOAD, a, d);
    @(negedge clk); idle(p);
  endtask

  // Read with load; flow or pipelined latency follows the port's mode.
  task automatic rd_chk(input int p, input logic [AW-1:0] a, input logic [DW-1:0] exp,
                        input string req);
    drive_req(p, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, C_LOAD, a, '0);
    @(negedge clk); idle(p);
    check(drive_of(p) == 1'b0, "R4 no drive before latency", {17'd0, drive_of(p)}, '0);
    @(negedge clk);
    if (two_st[p]) begin
      check(drive_of(p) == 1'b0, "R5 no drive after one edge", {17'd0, drive_of(p)}, '0);
      @(negedge clk);
    end
    check(drive_of(p) == 1'b1, req, {17'd0, drive_of(p)}, 18'd1);
    check(dout_of(p) == exp, req, dout_of(p), exp);
  endtask

  // Left port vectors: {rd, hi_n, lo_n, addr[10:0], din[17:0], expect[17:0]}.
  localparam int NV = 11;
  localparam logic [49:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 11'd5, 18'h12345, 18'h00000},
    {1'b1, 1'b1, 1'b1, 11'd5, 18'h00000, 18'h12345},
    {1'b0, 1'b0, 1'b1, 11'd5, 18'h3FFFF, 18'h00000},
    {1'b1, 1'b1, 1'b1, 11'd5, 18'h00000, 18'h3FF45},
    {1'b0, 1'b1, 1'b0, 11'd5, 18'h00000, 18'h00000},
    {1'b1, 1'b1, 1'b1, 11'd5, 18'h00000, 18'h3FE00},
    {1'b0, 1'b1, 1'b1, 11'd5, 18'h00000, 18'h00000},
    {1'b1, 1'b1, 1'b1, 11'd5, 18'h00000, 18'h3FE00},
    {1'b0, 1'b0, 1'b0, 11'd7, 18'h0ABCD, 18'h00000},
    {1'b1, 1'b1, 1'b1, 11'd7, 18'h00000, 18'h0ABCD},
    {1'b1, 1'b1, 1'b1, 11'd5, 18'h00000, 18'h3FE00}
  };

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired act=%h exp=%h", 18'd0, 18'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    for (int p = 0; p < 2; p++) begin
      idle(p); addr[p] = '0; din[p] = '0; oe_n[p] = 1'b0; two_st[p] = 1'b0;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    check(drive_l == 1'b0, "R1 left drive in reset", {17'd0, drive_l}, '0);
    check(drive_r == 1'b0, "R1 right drive in reset", {17'd0, drive_r}, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(drive_l == 1'b0 && drive_r == 1'b0, "R1 drive after release",
          {16'd0, drive_l, drive_r}, '0);

    // R1: counter starts at 0, so a hold-mode write lands at word 0
    drive_req(0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, C_HOLD, 11'd9, 18'h00111);
    @(negedge clk); idle(0);
    rd_chk(0, 11'd0, 18'h00111, "R1 counter zero after reset");

    // R3 R4 R9: lane merges and flow-through reads through the vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][49]) rd_chk(0, VEC[i][46:36], VEC[i][17:0], "R3 lane table read");
      else            wr(0, VEC[i][46:36], VEC[i][35:18], VEC[i][48], VEC[i][47]);
    end

    // R9: shared array across ports
    rd_chk(1, 11'd7, 18'h0ABCD, "R9 right sees left write");
    wr(1, 11'd60, 18'h24680, 1'b0, 1'b0);
    rd_chk(0, 11'd60, 18'h24680, "R9 left sees right write");

    // R8: output enable acts without a clock
    oe_n[0] = 1'b1;
    drive_req(0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, C_LOAD, 11'd5, '0);
    @(negedge clk); idle(0);
    @(negedge clk);
    check(drive_l == 1'b0, "R8 drive held off", {17'd0, drive_l}, '0);
    oe_n[0] = 1'b0; #1;
    check(drive_l == 1'b1, "R8 drive on without clock", {17'd0, drive_l}, 18'd1);
    check(dout_l == 18'h3FE00, "R8 data", dout_l, 18'h3FE00);
    oe_n[0] = 1'b1; #1;
    check(drive_l == 1'b0, "R8 drive off without clock", {17'd0, drive_l}, '0);
    oe_n[0] = 1'b0;
    @(negedge clk);

    // R2: deselected writes and reads
    drive_req(0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, C_LOAD, 11'd5, 18'h00000);
    @(negedge clk); idle(0);
    drive_req(0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, C_LOAD, 11'd5, 18'h00000);
    @(negedge clk); idle(0);
    rd_chk(0, 11'd5, 18'h3FE00, "R2 deselected write ignored");
    drive_req(0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, C_LOAD, 11'd5, '0);
    @(negedge clk); idle(0);
    @(negedge clk);
    check(drive_l == 1'b0, "R2 deselected read no drive", {17'd0, drive_l}, '0);

    // R6: load, step, hold during a burst
    drive_req(0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, C_LOAD, 11'd20, 18'h0000A);
    @(negedge clk);
    drive_req(0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, C_STEP, 11'd99, 18'h0000B);
    @(negedge clk);
    drive_req(0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, C_HOLD, 11'd99, 18'h0000C);
    @(negedge clk);
    drive_req(0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, C_STEP, 11'd99, 18'h0000E);
    @(negedge clk); idle(0);
    rd_chk(0, 11'd20, 18'h0000A, "R6 load address");
    rd_chk(0, 11'd21, 18'h0000C, "R6 step then hold");
    rd_chk(0, 11'd22, 18'h0000E, "R6 step after hold");

    // R6: clear beats load
    wr(0, 11'd30, 18'h00777, 1'b0, 1'b0);
    drive_req(0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'b001, 11'd30, 18'h0F00F);
    @(negedge clk); idle(0);
    rd_chk(0, 11'd0, 18'h0F00F, "R6 clear priority target");
    rd_chk(0, 11'd30, 18'h00777, "R6 load address untouched");

    // R7: wrap from the top address
    drive_req(0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, C_LOAD, 11'd2047, 18'h11111);
    @(negedge clk);
    drive_req(0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, C_STEP, 11'd0, 18'h22222);
    @(negedge clk); idle(0);
    rd_chk(0, 11'd2047, 18'h11111, "R7 top word");
    rd_chk(0, 11'd0, 18'h22222, "R7 wrapped to zero");

    // R10: same-word writes in one cycle
    drive_req(0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, C_LOAD, 11'd40, 18'h0F0F0);
    drive_req(1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, C_LOAD, 11'd40, 18'h30303);
    @(negedge clk); idle(0); idle(1);
    rd_chk(1, 11'd40, 18'h0F0F0, "R10 left wins full word");
    drive_req(0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, C_LOAD, 11'd41, 18'h3FFFF);
    drive_req(1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, C_LOAD, 11'd41, 18'h00000);
    @(negedge clk); idle(0); idle(1);
    rd_chk(0, 11'd41, 18'h3FE00, "R10 per-lane merge");

    // R11: read during the other port's write returns old data
    wr(0, 11'd50, 18'h12121, 1'b0, 1'b0);
    drive_req(0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, C_LOAD, 11'd50, 18'h34343);
    drive_req(1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, C_LOAD, 11'd50, '0);
    @(negedge clk); idle(0); idle(1);
    @(negedge clk);
    check(drive_r == 1'b1 && dout_r == 18'h12121, "R11 old data on collision",
          dout_r, 18'h12121);
    rd_chk(0, 11'd50, 18'h34343, "R11 new data afterwards");

    // R5: pipelined right port
    two_st[1] = 1'b1;
    repeat (3) @(negedge clk);
    rd_chk(1, 11'd7, 18'h0ABCD, "R5 pipelined read");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule